// File: doc/BRIEF.md
# Serial Display RAM Slave Interface

This block is the device-side end of a four-wire host link on a display driver. The host frames each transfer with an active-high abort line. It clocks bits in on a write strobe and clocks read bits out on a separate read strobe. One shared data line carries the bits. The first three bits of a frame give the mode. A data mode then takes a 7-bit nibble address and moves 4-bit nibbles into or out of an internal 128-entry display RAM. The address steps forward after every nibble. Command mode delivers 8-bit command bytes to the rest of the chip as a one-cycle strobe.

All host lines are resampled in the system clock domain, and strobe edges are found from the resampled values. The bidirectional data line is given as three pins: an input, an output and an output enable that drives the pad buffer.

Top module: `disp_ram_serial_if`

## Requirements
- R1: After reset, and before any frame is sent, `dat_oe` and `cmd_stb` are 0.
- R2: While `sel_n` is low, the first three `dat_i` bits taken on `wclk` rising edges form the mode, first bit received first. 110 is read, 101 is write (with optional read-back) and 100 is command. Any other value makes the block ignore the line until `sel_n` goes high.
- R3: After a data-mode code, the next seven `wclk` bits are the nibble address, most significant bit first.
- R4: In write mode, each group of four `wclk` bits is one nibble, least significant bit first. The nibble is stored at the current address.
- R5: In read mode, each `rclk` falling edge puts the next bit of the addressed nibble on `dat_o`, least significant bit first, with `dat_oe` high.
- R6: The address increments after every completed nibble in read or write mode, and it wraps from 127 to 0.
- R7: In write mode, `rclk` falling edges return the stored bits of the current nibble, least significant bit first. A following four-bit `wclk` write replaces that nibble, and the next stored nibble goes to the next address.
- R8: A command frame has nine `wclk` bits. The first bit becomes `cmd_byte[7]`, the eighth becomes `cmd_byte[0]` and the ninth is ignored. Each completed frame raises `cmd_stb` for exactly one clock.
- R9: After a command frame, further command frames are accepted without repeating the mode code, for as long as `sel_n` stays low.
- R10: Raising `sel_n` releases `dat_oe`, discards any partial nibble, address or code, and clears the mode. After `sel_n` goes low again, a new mode code is required.
- R11: `dat_oe` is high only in a data mode, after an `rclk` fall. In write mode it drops at the next `wclk` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host select; high aborts and resets the link |
| wclk | input | 1 | Host write strobe; bits taken on its rise |
| rclk | input | 1 | Host read strobe; bits driven on its fall |
| dat_i | input | 1 | Data line as seen at the pad |
| dat_o | output | 1 | Read data to the pad |
| dat_oe | output | 1 | Pad driver enable |
| cmd_stb | output | 1 | One-cycle pulse when a command byte is complete |
| cmd_byte | output | 8 | Last completed command byte |

## Verification
A table of single-nibble write-then-read pairs covers many addresses and nibble values. A wrong bit order in the address or in the data shows up as a mismatch on the read-back. Bursts that start at 126 separate correct wrapping from overflow into a wrong location. A read-back followed by a write on the same nibble tells read-modify-write apart from a plain write. Back-to-back command frames, an undefined mode code and an abort in the middle of a nibble show whether mode state is kept or cleared when it should be.

// File: rtl/disp_ram_serial_if.sv
module disp_ram_serial_if #(
  parameter int ADDR_W = 7,
  parameter int NIB_W  = 4,
  parameter int SYNC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       wclk,
  input  logic       rclk,
  input  logic       dat_i,
  output logic       dat_o,
  output logic       dat_oe,
  output logic       cmd_stb,
  output logic [7:0] cmd_byte
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2((ADDR_W > 9 ? ADDR_W : 9) + 1);
  localparam int RB_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  typedef enum logic [2:0] {S_ID, S_ADDR, S_RD, S_WR, S_CMD, S_SKIP} st_t;

  logic [SYNC-1:0] sy_sel, sy_wr, sy_rd, sy_din;
  logic            wr_q, rd_q;
  logic            sel_s, wr_s, rd_s, din_s, wr_rise, rd_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy_sel <= '1; sy_wr <= '0; sy_rd <= '1; sy_din <= '0;
      wr_q <= 1'b0; rd_q <= 1'b1;
    end else begin
      sy_sel <= {sy_sel[SYNC-2:0], sel_n};
      sy_wr  <= {sy_wr[SYNC-2:0], wclk};
      sy_rd  <= {sy_rd[SYNC-2:0], rclk};
      sy_din <= {sy_din[SYNC-2:0], dat_i};
      wr_q   <= sy_wr[SYNC-1];
      rd_q   <= sy_rd[SYNC-1];
    end

  assign sel_s   = sy_sel[SYNC-1];
  assign wr_s    = sy_wr[SYNC-1];
  assign rd_s    = sy_rd[SYNC-1];
  assign din_s   = sy_din[SYNC-1];
  assign wr_rise = wr_s & ~wr_q;
  assign rd_fall = ~rd_s & rd_q;

  st_t               st;
  logic              rd_mode;
  logic [7:0]        sh;
  logic [CNT_W-1:0]  cnt;
  logic [RB_W-1:0]   rbit;
  logic [ADDR_W-1:0] addr;
  logic [NIB_W-2:0]  wnib;
  logic [NIB_W-1:0]  mem [DEPTH];

  wire nib_done = (cnt == CNT_W'(NIB_W - 1));
  wire mem_we   = !sel_s && st == S_WR && wr_rise && nib_done;

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= {din_s, wnib};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_ID; rd_mode <= 1'b0; sh <= '0; cnt <= '0; rbit <= '0;
      addr <= '0; wnib <= '0; dat_o <= 1'b0; dat_oe <= 1'b0;
      cmd_stb <= 1'b0; cmd_byte <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (sel_s) begin
        st <= S_ID; cnt <= '0; rbit <= '0; sh <= '0; dat_oe <= 1'b0;
      end else begin
        case (st)
          S_ID: if (wr_rise) begin
            sh  <= {sh[6:0], din_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(2)) begin
              cnt <= '0;
              case ({sh[1:0], din_s})
                3'b110:  begin st <= S_ADDR; rd_mode <= 1'b1; end
                3'b101:  begin st <= S_ADDR; rd_mode <= 1'b0; end
                3'b100:  st <= S_CMD;
                default: st <= S_SKIP;
              endcase
            end
          end
          S_ADDR: if (wr_rise) begin
            addr <= {addr[ADDR_W-2:0], din_s};
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt <= '0;
              rbit <= '0;
              st  <= rd_mode ? S_RD : S_WR;
            end
          end
          S_RD: if (rd_fall) begin
            dat_o  <= mem[addr][rbit];
            dat_oe <= 1'b1;
            rbit   <= (rbit == RB_W'(NIB_W - 1)) ? '0 : rbit + 1'b1;
            if (rbit == RB_W'(NIB_W - 1)) addr <= addr + 1'b1;
          end
          S_WR: begin
            if (rd_fall) begin
              dat_o  <= mem[addr][rbit];
              dat_oe <= 1'b1;
              rbit   <= (rbit == RB_W'(NIB_W - 1)) ? '0 : rbit + 1'b1;
            end
            if (wr_rise) begin
              dat_oe <= 1'b0;
              if (nib_done) begin
                cnt  <= '0;
                rbit <= '0;
                addr <= addr + 1'b1;
              end else begin
                wnib[cnt[RB_W-1:0]] <= din_s;
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_CMD: if (wr_rise) begin
            if (cnt == CNT_W'(8)) begin
              cmd_byte <= sh;
              cmd_stb  <= 1'b1;
              cnt      <= '0;
            end else begin
              sh  <= {sh[6:0], din_s};
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

  a_r1_quiet_reset: assert property (@(posedge clk) $rose(rst_n) |-> !dat_oe && !cmd_stb);

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  a_r8_strobe_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(st) == S_CMD);

  a_r10_sel_releases: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !dat_oe && st == S_ID);

  a_r11_oe_in_data_mode: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> (st == S_RD || st == S_WR));

  a_r6_step_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> addr == $past(addr) + 1'b1);
endmodule

// File: tb/tb_disp_ram_serial_if.sv
module tb_disp_ram_serial_if;
  logic clk = 0, rst_n = 0, sel_n = 1, wclk = 0, rclk = 1, dat_i = 0;
  logic dat_o, dat_oe, cmd_stb;
  logic [7:0] cmd_byte;
  int checks = 0, errors = 0, stb_cnt = 0;
  logic [7:0] last_cmd = '0;
  bit done = 0;

  always #4 clk = ~clk;

  disp_ram_serial_if dut (.clk, .rst_n, .sel_n, .wclk, .rclk, .dat_i,
                          .dat_o, .dat_oe, .cmd_stb, .cmd_byte);

  always @(negedge clk) if (cmd_stb) begin stb_cnt++; last_cmd = cmd_byte; end

  // {addr[6:0], nibble[3:0]}
  localparam logic [10:0] VEC [8] = '{
    {7'd0,   4'h3}, {7'd1,   4'hC}, {7'd64,  4'h9}, {7'd85,  4'h6},
    {7'd42,  4'hF}, {7'd127, 4'h1}, {7'd99,  4'h0}, {7'd7,   4'hE}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_c(int n); repeat (n) @(negedge clk); endtask
  task automatic sel(bit v); sel_n = v; wait_c(6); endtask

  task automatic wbit(bit b);
    dat_i = b; wait_c(4); wclk = 1; wait_c(4); wclk = 0;
  endtask

  task automatic rbit(output bit b, output bit oe);
    rclk = 0; wait_c(6); b = dat_o; oe = dat_oe; rclk = 1; wait_c(4);
  endtask

  task automatic send_id(logic [2:0] id);
    for (int i = 2; i >= 0; i--) wbit(id[i]);
  endtask

  task automatic send_addr(logic [6:0] a);
    for (int i = 6; i >= 0; i--) wbit(a[i]);
  endtask

  task automatic send_nib(logic [3:0] n);
    for (int i = 0; i < 4; i++) wbit(n[i]);
  endtask

  task automatic get_nib(output logic [3:0] n, output bit all_oe);
    bit b, oe;
    all_oe = 1;
    for (int i = 0; i < 4; i++) begin rbit(b, oe); n[i] = b; all_oe &= oe; end
  endtask

  task automatic wr1(logic [6:0] a, logic [3:0] n);
    sel(0); send_id(3'b101); send_addr(a); send_nib(n); sel(1);
  endtask

  task automatic rd1(logic [6:0] a, output logic [3:0] n);
    bit oe;
    sel(0); send_id(3'b110); send_addr(a); get_nib(n, oe); sel(1);
  endtask

  task automatic send_cmd(logic [7:0] c, bit extra);
    for (int i = 7; i >= 0; i--) wbit(c[i]);
    wbit(extra);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] n;
    bit oe, b;
    int s0;
    wait_c(3);
    chk("R1 oe at reset", dat_oe, 0);
    chk("R1 stb at reset", cmd_stb, 0);
    rst_n = 1; wait_c(6);
    chk("R1 oe after reset", dat_oe, 0);

    for (int v = 0; v < 8; v++) begin
      wr1(VEC[v][10:4], VEC[v][3:0]);
      rd1(VEC[v][10:4], n);
      chk("R2 R3 R4 R5 vector readback", n, VEC[v][3:0]);
    end

    // R6 burst write across wrap, burst read back
    sel(0); send_id(3'b101); send_addr(7'd126);
    send_nib(4'hA); send_nib(4'h5); send_nib(4'h7); sel(1);
    sel(0); send_id(3'b110); send_addr(7'd126);
    get_nib(n, oe); chk("R6 burst nib 126", n, 4'hA);
    chk("R5 oe while reading", oe, 1);
    get_nib(n, oe); chk("R6 burst nib 127", n, 4'h5);
    get_nib(n, oe); chk("R6 wrap to 0", n, 4'h7);
    sel(1);
    chk("R10 oe released on sel high", dat_oe, 0);

    // R7 read-modify-write
    wr1(7'd10, 4'h5); wr1(7'd11, 4'h2);
    sel(0); send_id(3'b101); send_addr(7'd10);
    get_nib(n, oe); chk("R7 readback before write", n, 4'h5);
    send_nib(4'hB);
    chk("R11 oe dropped on write", dat_oe, 0);
    get_nib(n, oe); chk("R7 next address readback", n, 4'h2);
    sel(1);
    rd1(7'd10, n); chk("R7 modified nibble", n, 4'hB);

    // R8 R9 consecutive commands
    s0 = stb_cnt;
    sel(0); send_id(3'b100); send_cmd(8'hA5, 1'b1);
    chk("R8 strobe count", stb_cnt - s0, 1);
    chk("R8 command byte", last_cmd, 8'hA5);
    send_cmd(8'h3C, 1'b0);
    chk("R9 second strobe without code", stb_cnt - s0, 2);
    chk("R9 second byte", last_cmd, 8'h3C);
    for (int i = 7; i >= 4; i--) wbit(i[0]);
    sel(1);
    chk("R10 partial command dropped", stb_cnt - s0, 2);

    // R10 abort mid-nibble
    wr1(7'd20, 4'h9);
    sel(0); send_id(3'b101); send_addr(7'd20); wbit(0); wbit(1); sel(1);
    rd1(7'd20, n); chk("R10 partial nibble discarded", n, 4'h9);
    // R10 new code required after abort: bits taken as code 010 -> ignored
    sel(0); send_id(3'b100); wbit(1); sel(1);
    sel(0); send_id(3'b010); send_addr(7'd20); send_nib(4'h0); sel(1);
    rd1(7'd20, n); chk("R10 no mode carried over", n, 4'h9);

    // R2 undefined code ignored; R11 no drive
    sel(0); send_id(3'b111); send_addr(7'd20); send_nib(4'h1);
    rbit(b, oe); chk("R11 no drive after bad code", oe, 0);
    sel(1);
    rd1(7'd20, n); chk("R2 undefined code ignored", n, 4'h9);

    // R11 no drive in read mode before first rclk fall
    sel(0); send_id(3'b110); send_addr(7'd20);
    chk("R11 oe low before rclk fall", dat_oe, 0);
    sel(1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule